// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the digital edge of a stereo codec. It moves samples over a three-wire serial link whose bit clock and word-select line come from an external master, so the block is always the slave. Playback samples arrive one bit at a time on a serial input. They are gathered into a left/right pair of parallel words and handed to the signal-processing side with a one-cycle strobe. Record samples are taken as parallel left/right words and sent out on a serial output in the same frame timing.

The block runs on a fast local system clock. Bit clock, word select and serial input pass through a synchronizer, and all serial activity is decoded from the detected bit-clock edges. A 3-bit format selector sets the framing. There are three framings: I2S, MSB-justified and LSB-justified. LSB-justified works at 16, 18 or 20 bits. Three combined codes receive LSB-justified data while transmitting MSB-justified data. The configuration is held static while the port runs, and a change is followed by a reset. Every parallel word is W bits wide and left-aligned. A shorter word keeps its bits at the top and has zeros below.

Top module: `sap_port`

## Requirements
- R1: `fmt_sel` selects the framing as follows. 0 is I2S both ways. 1 is MSB-justified both ways. 2, 3 and 4 are LSB-justified both ways at 16, 18 and 20 bits. 5, 6 and 7 receive LSB-justified at 16, 18 and 20 bits and transmit MSB-justified.
- R2: In I2S, word select low marks the left channel. The received MSB sits in the second bit period of a half-frame, and the next W bits form the word.
- R3: In MSB-justified reception, word select high marks the left channel. The MSB sits in the first bit period of a half-frame.
- R4: In LSB-justified reception of N bits, only the last N bits before the next word-select change are kept. They are placed in the top N bits of the output word, and the low W-N bits are zero.
- R5: After a right half-frame ends, `play_left` and `play_right` are presented together with `play_valid` high for exactly one clock. A pair is produced only if both halves began on an observed word-select change. Any half-frame already in progress at reset is dropped.
- R6: In I2S transmission, `sdata_o` changes only after a falling bit-clock edge. The MSB goes out in the second bit period of a half-frame, and every bit after the W-th is zero.
- R7: In MSB-justified transmission, the MSB goes out in the first bit period of a half-frame, followed by the rest of the word and then zeros.
- R8: In LSB-justified transmission of N bits, the top N bits of the word fill the last N bit periods of the half-frame. The half-frame length is measured from the preceding complete half-frame. Until one full half-frame has been measured, the output stays zero.
- R9: In the combined codes, reception follows R4 and transmission follows R7 in the same frame.
- R10: While reset is held and just after it, `sdata_o` is 0, `play_valid` is 0 and `play_left` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 3 | Framing selector (see R1) |
| bck_i | input | 1 | Serial bit clock from the master |
| ws_i | input | 1 | Word select from the master |
| sdata_i | input | 1 | Serial playback data |
| sdata_o | output | 1 | Serial record data |
| play_left | output | W (20) | Received left word, left-aligned |
| play_right | output | W (20) | Received right word, left-aligned |
| play_valid | output | 1 | One-cycle strobe for a new received pair |
| rec_left | input | W (20) | Left word to transmit, left-aligned |
| rec_right | input | W (20) | Right word to transmit, left-aligned |

## Verification
The hardest state to reach from the ports is the start-up window. Here the transmitter does not yet know the half-frame length, and the receiver must drop a pair whose left half began before reset. Each scenario releases reset in the middle of a left half-frame, then sends one full right half-frame before any real frame. The first right half-frame produces no strobe, and in the LSB-justified transmit codes it must go out as all zeros even though a nonzero right word is loaded. Slot lengths equal to the word length and longer than it are both used. This places the LSB-justified window at the very start of a half-frame and also well inside one.

// File: rtl/sap_pkg.sv
// Shared types for the serial audio port: framing kinds and the decoded
// configuration. Assumes every LSB-justified length fits in LEN_W bits.
package sap_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        FR_I2S = 2'd0,
        FR_MSB = 2'd1,
        FR_LSB = 2'd2
    } frame_e;

    typedef struct packed {
        frame_e             rx_kind;
        logic [LEN_W-1:0]   rx_len;
        frame_e             tx_kind;
        logic [LEN_W-1:0]   tx_len;
    } port_cfg_t;

    // Map the 3-bit format code onto receive and transmit framings.
    function automatic port_cfg_t decode_fmt(input logic [2:0] code);
        port_cfg_t c;
        c.rx_kind = FR_LSB;
        c.tx_kind = FR_LSB;
        c.rx_len  = LEN_W'(16);
        c.tx_len  = LEN_W'(16);
        case (code)
            3'd0: begin c.rx_kind = FR_I2S; c.tx_kind = FR_I2S; end
            3'd1: begin c.rx_kind = FR_MSB; c.tx_kind = FR_MSB; end
            3'd2: begin end
            3'd3: begin c.rx_len = LEN_W'(18); c.tx_len = LEN_W'(18); end
            3'd4: begin c.rx_len = LEN_W'(20); c.tx_len = LEN_W'(20); end
            3'd5: begin c.tx_kind = FR_MSB; end
            3'd6: begin c.tx_kind = FR_MSB; c.rx_len = LEN_W'(18); end
            default: begin c.tx_kind = FR_MSB; c.rx_len = LEN_W'(20); end
        endcase
        return c;
    endfunction

    // Left channel is marked by word select high in every framing but I2S.
    function automatic logic left_when_high(input frame_e k);
        return k != FR_I2S;
    endfunction

endpackage

// File: rtl/sap_sync.sv
// Brings bit clock, word select and serial data into the system clock
// domain through STAGES flops each, and flags bit-clock edges.
// Assumes STAGES >= 2 and at least two system clocks per bit-clock phase.
// All three lines share one chain depth, so word select and data stay
// aligned with the edge pulses.
module sap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic dat_i,
    output logic bck_rise,
    output logic bck_fall,
    output logic ws_s,
    output logic dat_s
);

    logic [STAGES-1:0] bck_p;
    logic [STAGES-1:0] ws_p;
    logic [STAGES-1:0] dat_p;
    logic              bck_q;

    // Shift the raw inputs through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_p <= '0;
            ws_p  <= '0;
            dat_p <= '0;
            bck_q <= 1'b0;
        end else begin
            bck_p <= {bck_p[STAGES-2:0], bck_i};
            ws_p  <= {ws_p[STAGES-2:0], ws_i};
            dat_p <= {dat_p[STAGES-2:0], dat_i};
            bck_q <= bck_p[STAGES-1];
        end
    end

    assign bck_rise = bck_p[STAGES-1] & ~bck_q;
    assign bck_fall = ~bck_p[STAGES-1] & bck_q;
    assign ws_s     = ws_p[STAGES-1];
    assign dat_s    = dat_p[STAGES-1];

endmodule

// File: rtl/sap_rx.sv
// Serial receiver: samples data on each rising bit-clock edge and builds
// the left and right words for the selected framing. It emits the pair with
// a one-cycle strobe when the right half-frame closes. Half-frames are
// delimited by word-select changes, and the first one after reset is
// treated as incomplete.
module sap_rx
    import sap_pkg::*;
#(
    parameter int W  = 20,
    parameter int CW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise,
    input  logic             ws_s,
    input  logic             dat_s,
    input  frame_e           kind,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     left_o,
    output logic [W-1:0]     right_o,
    output logic             valid_o
);

    logic          primed;
    logic          framed;
    logic          prev_ws;
    logic          have_left;
    logic [CW-1:0] k;
    logic [W-1:0]  msb_q;
    logic [W-1:0]  lsb_q;
    logic [W-1:0]  left_q;

    logic          change;
    logic [CW-1:0] k_next;
    logic [W-1:0]  msb_next;
    logic [W-1:0]  lsb_next;
    logic [W-1:0]  done_word;
    logic          done_left;
    int            off;

    // Work out the bit index, the word under assembly and the finished word.
    always_comb begin
        change   = primed && (ws_s != prev_ws);
        k_next   = change ? '0 : ((k == {CW{1'b1}}) ? k : k + 1'b1);
        off      = int'(k_next) - ((kind == FR_I2S) ? 1 : 0);
        msb_next = change ? '0 : msb_q;
        if (kind != FR_LSB && off >= 0 && off < W)
            msb_next = msb_next | ({{(W-1){1'b0}}, dat_s} << (W - 1 - off));
        lsb_next  = change ? {{(W-1){1'b0}}, dat_s} : {lsb_q[W-2:0], dat_s};
        done_word = (kind == FR_LSB) ? (lsb_q << (W - int'(len))) : msb_q;
        done_left = left_when_high(kind) ? prev_ws : ~prev_ws;
    end

    // Advance on each rising bit-clock edge and publish completed pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            framed    <= 1'b0;
            prev_ws   <= 1'b0;
            have_left <= 1'b0;
            k         <= '0;
            msb_q     <= '0;
            lsb_q     <= '0;
            left_q    <= '0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (bit_rise) begin
                primed  <= 1'b1;
                prev_ws <= ws_s;
                k       <= k_next;
                msb_q   <= msb_next;
                lsb_q   <= lsb_next;
                if (change) begin
                    framed <= 1'b1;
                    if (framed) begin
                        if (done_left) begin
                            left_q    <= done_word;
                            have_left <= 1'b1;
                        end else if (have_left) begin
                            left_o    <= left_q;
                            right_o   <= done_word;
                            valid_o   <= 1'b1;
                            have_left <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    valid_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_rise));

endmodule

// File: rtl/sap_tx.sv
// Serial transmitter: picks the output bit for each bit period on the
// falling bit-clock edge. The word for a half-frame is latched when that
// half-frame opens. For LSB-justified output, the half-frame length is
// taken from the last complete half-frame, and the line stays zero until
// one has been measured. Assumes a steady frame length.
module sap_tx
    import sap_pkg::*;
#(
    parameter int W  = 20,
    parameter int CW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_fall,
    input  logic             ws_s,
    input  frame_e           kind,
    input  logic [LEN_W-1:0] len,
    input  logic [W-1:0]     word_left,
    input  logic [W-1:0]     word_right,
    output logic             dout
);

    logic          primed;
    logic          seen_chg;
    logic          len_known;
    logic          prev_ws;
    logic [CW-1:0] j;
    logic [CW-1:0] len_q;
    logic [W-1:0]  word_q;

    logic          change;
    logic [CW-1:0] j_plus;
    logic [CW-1:0] j_next;
    logic [CW-1:0] len_now;
    logic          known_now;
    logic [W-1:0]  in_word;
    logic [W-1:0]  cur;
    logic [W-1:0]  shifted;
    logic          bit_next;
    int            sent;
    int            limit;

    // Select the next output bit from the framing and the bit index.
    always_comb begin
        change    = primed && (ws_s != prev_ws);
        j_plus    = (j == {CW{1'b1}}) ? j : j + 1'b1;
        j_next    = change ? '0 : j_plus;
        len_now   = (change && seen_chg) ? j_plus : len_q;
        known_now = len_known || (change && seen_chg);
        in_word   = ((left_when_high(kind) ? ws_s : ~ws_s)) ? word_left : word_right;
        cur       = change ? in_word : word_q;
        sent      = -1;
        limit     = W;
        case (kind)
            FR_I2S: sent = int'(j_next) - 1;
            FR_MSB: sent = int'(j_next);
            default: begin
                limit = int'(len);
                if (known_now && int'(len_now) >= int'(len))
                    sent = int'(j_next) - (int'(len_now) - int'(len));
            end
        endcase
        shifted  = '0;
        bit_next = 1'b0;
        if (sent >= 0 && sent < limit) begin
            shifted  = cur << sent;
            bit_next = shifted[W-1];
        end
    end

    // Update the line and the framing state on each falling bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            seen_chg  <= 1'b0;
            len_known <= 1'b0;
            prev_ws   <= 1'b0;
            j         <= '0;
            len_q     <= '0;
            word_q    <= '0;
            dout      <= 1'b0;
        end else if (bit_fall) begin
            primed  <= 1'b1;
            prev_ws <= ws_s;
            j       <= j_next;
            dout    <= bit_next;
            if (change) begin
                word_q   <= in_word;
                seen_chg <= 1'b1;
                if (seen_chg) begin
                    len_q     <= j_plus;
                    len_known <= 1'b1;
                end
            end
        end
    end

    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_fall) |-> $stable(dout));

    // R8
    lsb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == FR_LSB && !len_known) |-> !dout);

endmodule

// File: rtl/sap_port.sv
// Top of the slave serial audio port. It decodes the format selector,
// synchronizes the serial lines, and joins the receiver (playback words
// out) with the transmitter (record words in). Assumes the format is
// static between resets.
module sap_port
    import sap_pkg::*;
#(
    parameter int W           = 20,
    parameter int MAX_SLOT    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   fmt_sel,
    input  logic         bck_i,
    input  logic         ws_i,
    input  logic         sdata_i,
    output logic         sdata_o,
    output logic [W-1:0] play_left,
    output logic [W-1:0] play_right,
    output logic         play_valid,
    input  logic [W-1:0] rec_left,
    input  logic [W-1:0] rec_right
);

    localparam int CW = $clog2(MAX_SLOT + 1);

    port_cfg_t cfg;
    logic      bit_rise;
    logic      bit_fall;
    logic      ws_s;
    logic      dat_s;

    assign cfg = decode_fmt(fmt_sel);

    sap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_i    (bck_i),
        .ws_i     (ws_i),
        .dat_i    (sdata_i),
        .bck_rise (bit_rise),
        .bck_fall (bit_fall),
        .ws_s     (ws_s),
        .dat_s    (dat_s)
    );

    sap_rx #(.W(W), .CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .ws_s     (ws_s),
        .dat_s    (dat_s),
        .kind     (cfg.rx_kind),
        .len      (cfg.rx_len),
        .left_o   (play_left),
        .right_o  (play_right),
        .valid_o  (play_valid)
    );

    sap_tx #(.W(W), .CW(CW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_fall   (bit_fall),
        .ws_s       (ws_s),
        .kind       (cfg.tx_kind),
        .len        (cfg.tx_len),
        .word_left  (rec_left),
        .word_right (rec_right),
        .dout       (sdata_o)
    );

endmodule

// File: tb/sim_sap_port.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_sap_port;

    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int W     = 20;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   fmt_sel;
    logic         bck_i, ws_i, sdata_i;
    logic         sdata_o;
    logic [W-1:0] play_left, play_right;
    logic         play_valid;
    logic [W-1:0] rec_left, rec_right;

    int nvec = 0;
    int nerr = 0;
    int ngot = 0;
    bit done = 1'b0;
    logic [W-1:0] got_l [0:7];
    logic [W-1:0] got_r [0:7];
    logic [W-1:0] exp_l [0:7];
    logic [W-1:0] exp_r [0:7];

    always #(CLK_P/2) clk = ~clk;

    sap_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .bck_i(bck_i), .ws_i(ws_i), .sdata_i(sdata_i), .sdata_o(sdata_o),
        .play_left(play_left), .play_right(play_right), .play_valid(play_valid),
        .rec_left(rec_left), .rec_right(rec_right)
    );

    // Collect received pairs through the port.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && play_valid === 1'b1) begin
            if (ngot < 8) begin
                got_l[ngot] = play_left;
                got_r[ngot] = play_right;
            end
            ngot = ngot + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Framing kinds per format code: 0 I2S, 1 MSB, 2 LSB (R1).
    function automatic int rx_kind(input int f);
        return (f == 0) ? 0 : (f == 1) ? 1 : 2;
    endfunction
    function automatic int tx_kind(input int f);
        return (f == 0) ? 0 : (f == 1 || f >= 5) ? 1 : 2;
    endfunction
    function automatic int lsb_n(input int f);
        return (f == 2 || f == 5) ? 16 : (f == 3 || f == 6) ? 18 : 20;
    endfunction

    // Bit carried in period j of an S-period half-frame.
    function automatic logic enc(input int kind, input int n, input int s,
                                 input int j, input logic [W-1:0] w);
        if (kind == 0) return (j >= 1 && j <= W) ? w[W-j] : 1'b0;
        if (kind == 1) return (j < W) ? w[W-1-j] : 1'b0;
        return (j >= s - n) ? w[W-1-(j-(s-n))] : 1'b0;
    endfunction

    function automatic logic [W-1:0] mkw(input int a, input int b);
        return W'((a * 40503 + b * 7919 + 12345) ^ (b << 9) ^ (a << 15));
    endfunction

    task automatic bit_period(input logic w, input logic d, output logic q);
        bck_i = 1'b0; ws_i = w; sdata_i = d;
        repeat (HALF) @(negedge clk);
        q = sdata_o;
        bck_i = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic half_frame(input logic w, input int kind, input int n, input int s,
                              input logic [W-1:0] word, output logic [63:0] cap);
        logic q;
        cap = '0;
        for (int j = 0; j < s; j++) begin
            bit_period(w, enc(kind, n, s, j, word), q);
            cap[j] = q;
        end
    endtask

    function automatic logic [63:0] exp_serial(input int kind, input int n, input int s,
                                               input logic [W-1:0] word);
        logic [63:0] v = '0;
        for (int j = 0; j < s; j++) v[j] = enc(kind, n, s, j, word);
        return v;
    endfunction

    // Reset with a format applied, checking the idle outputs (R10).
    task automatic do_reset(input int f, input logic leftw);
        rst_n = 1'b0; fmt_sel = 3'(f); bck_i = 1'b1; ws_i = leftw; sdata_i = 1'b0;
        rec_left = '0; rec_right = '0;
        repeat (4) @(negedge clk);
        chk("R10 reset dout/valid/left", {62'd0, sdata_o, play_valid} | {44'd0, play_left}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 after release", {62'd0, sdata_o, play_valid}, 64'd0);
        ngot = 0;
    endtask

    // One scenario: start mid-left, one dummy right half, nf frames, closing left.
    task automatic run_case(input int f, input int s, input int nf);
        int rk = rx_kind(f), tk = tx_kind(f), n = lsb_n(f);
        logic leftw = (rk == 0) ? 1'b0 : 1'b1;
        logic [63:0] cap;
        logic q;
        logic [W-1:0] lw, rw, mask;
        string rtag = (rk == 0) ? "R2" : (rk == 1) ? "R3" : (f >= 5) ? "R9" : "R4";
        string ttag = (tk == 0) ? "R6" : (tk == 2) ? "R8" : (f >= 5) ? "R9" : "R7";
        mask = (rk == 2) ? ({W{1'b1}} << (W - n)) : {W{1'b1}};
        do_reset(f, leftw);
        for (int j = 0; j < s / 2; j++) bit_period(leftw, 1'b1, q);
        // Dummy right half: no pair (R5); LSB transmit still blank (R8)
        rec_right = 20'hABCDE;
        half_frame(~leftw, rk, n, s, mkw(f, 99), cap);
        if (tk == 2) chk($sformatf("R1 R8 fmt=%0d blank before length known", f), cap, 64'd0);
        for (int fr = 0; fr < nf; fr++) begin
            lw = mkw(f * 8 + fr, 1); rw = mkw(f * 8 + fr, 2);
            exp_l[fr] = lw & mask; exp_r[fr] = rw & mask;
            rec_left = mkw(f * 8 + fr, 3); rec_right = mkw(f * 8 + fr, 4);
            half_frame(leftw, rk, n, s, lw, cap);
            chk($sformatf("R1 %s fmt=%0d tx left frame %0d", ttag, f, fr), cap,
                exp_serial(tk, n, s, rec_left));
            half_frame(~leftw, rk, n, s, rw, cap);
            chk($sformatf("R1 %s fmt=%0d tx right frame %0d", ttag, f, fr), cap,
                exp_serial(tk, n, s, rec_right));
        end
        rec_left = '0; rec_right = '0;
        half_frame(leftw, rk, n, s, '0, cap);
        chk($sformatf("R5 fmt=%0d pair count", f), 64'(ngot), 64'(nf));
        for (int fr = 0; fr < nf && fr < 8; fr++) begin
            chk($sformatf("R1 %s fmt=%0d rx left frame %0d", rtag, f, fr), 64'(got_l[fr]), 64'(exp_l[fr]));
            chk($sformatf("R1 %s fmt=%0d rx right frame %0d", rtag, f, fr), 64'(got_r[fr]), 64'(exp_r[fr]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL R5 watchdog act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        run_case(0, 24, 3);   // I2S, slot wider than word (R2, R6)
        run_case(1, 24, 3);   // MSB-justified, trailing zeros (R3, R7)
        run_case(1, 20, 2);   // MSB-justified, slot equals word
        run_case(2, 32, 2);   // LSB 16 (R4, R8)
        run_case(3, 24, 2);   // LSB 18
        run_case(4, 20, 2);   // LSB 20, window starts at first period
        run_case(5, 32, 2);   // combined, LSB 16 in (R9)
        run_case(6, 24, 2);   // combined, LSB 18 in
        run_case(7, 32, 2);   // combined, LSB 20 in
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule